// File: doc/BRIEF.md
# Control Structure Pointer Tracker

This block keeps the pointer bookkeeping of one logical processor that hosts guest control structures. Each control structure is known by the 64-bit physical address of its memory region. Two separate notions are tracked. The active set holds every structure that has been loaded and not yet cleared, and several structures may be in it at once. The current pointer names at most one structure, the one that read, write, launch, resume and store-pointer commands act on.

A command arrives as a one-cycle strobe with an opcode and an address. Load makes a structure active and also current. Clear takes a structure out of the active set, and if it was the current one, nothing is current afterwards. Operate-on-current commands do not use their address. They either get a grant pulse, which hands them to the datapath that accesses the structure, or an error pulse when nothing is current. Store-pointer returns the current pointer. Addresses must sit on a 4 KiB boundary. A misaligned load or clear, or a load of a new address when the table is full, is refused with an error pulse and changes nothing.

Top module: `ctx_ptr_tracker`

## Requirements
- R1: After a synchronous reset, cur_valid is 0, act_cnt is 0, and rsp_valid, op_grant, err_align, err_nocur and err_full are all 0.
- R2: An aligned load (cmd_op 1) makes its address active, increasing act_cnt if the address was not active already. It also sets cur_valid with cur_ptr equal to the address.
- R3: A load or clear (cmd_op 2) whose address has any of bits 11:0 set pulses err_align. The active set, act_cnt and the current pointer do not change.
- R4: An aligned clear of an active address removes it from the active set and decreases act_cnt. A clear of an address that is not active changes nothing and raises no error.
- R5: A clear of the current address drops cur_valid. A clear of any other address leaves cur_valid and cur_ptr unchanged.
- R6: The current pointer changes only when an aligned load succeeds or when the current address is cleared. Store and operate-on-current commands, idle cycles and refused commands leave it as it is.
- R7: The active table holds DEPTH entries (8 by default). A load of a new address while the table is full pulses err_full and changes no state. A load of an already active address while the table is full succeeds.
- R8: Store-pointer (cmd_op 3) pulses rsp_valid. rsp_ptr carries the current pointer, or all ones when nothing is current.
- R9: Read, write, launch and resume (cmd_op 4, 5, 6, 7) pulse op_grant when a structure is current. When nothing is current they pulse err_nocur instead, with no grant.
- R10: Every output is registered. A command sampled on one rising edge is reflected in the outputs right after that edge, and each pulse output lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 0 idle, 1 load, 2 clear, 3 store-pointer, 4 read, 5 write, 6 launch, 7 resume |
| cmd_addr | input | 64 | Physical address of the structure, used by load and clear |
| rsp_valid | output | 1 | Store-pointer response pulse |
| rsp_ptr | output | 64 | Returned pointer, all ones when nothing is current |
| op_grant | output | 1 | Operate-on-current command accepted |
| err_align | output | 1 | Misaligned load or clear refused |
| err_nocur | output | 1 | Operate-on-current command issued with nothing current |
| err_full | output | 1 | Load of a new address refused because the table is full |
| cur_valid | output | 1 | A current structure exists |
| cur_ptr | output | 64 | Current structure address, meaningful when cur_valid is 1 |
| act_cnt | output | 4 | Number of active structures |

## Verification
The bench goes after the boundaries between the active set and the current pointer. A design that treats a clear of a non-current structure as dropping the current one would lose cur_valid. A design that frees no slot on clear would report overflow early. The bench also fills the table and then reloads an existing address, which a design that checks fullness before the lookup would wrongly refuse. It drives misaligned loads and clears, where a design that still updates state would move cur_ptr or act_cnt. Finally, it issues store-pointer with nothing current, where a wrong design returns a stale pointer instead of all ones.

// File: rtl/ctx_ptr_pkg.sv
package ctx_ptr_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_LOAD   = 3'd1,
    OP_CLEAR  = 3'd2,
    OP_STORE  = 3'd3,
    OP_READ   = 3'd4,
    OP_WRITE  = 3'd5,
    OP_LAUNCH = 3'd6,
    OP_RESUME = 3'd7
  } ctx_op_e;

  function automatic logic op_uses_current(input ctx_op_e op);
    return (op == OP_READ) || (op == OP_WRITE) ||
           (op == OP_LAUNCH) || (op == OP_RESUME);
  endfunction

endpackage

// File: rtl/ctx_ptr_pick.sv
module ctx_ptr_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/ctx_ptr_cam.sv
module ctx_ptr_cam #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 52,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             free_any,
  output logic [IDX_W-1:0] free_idx,
  output logic [CNT_W-1:0] count
);

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] hit_vec;
  logic [DEPTH-1:0] free_vec;
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign hit_vec[g]  = vld_q[g] && (tag_mem[g] == look_tag);
    assign free_vec[g] = ~vld_q[g];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) tag_mem[g] <= look_tag;
    end

    always_ff @(posedge clk) begin
      if (rst) vld_q[g] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(g))) vld_q[g] <= 1'b1;
      else if (clr_en && (clr_idx == IDX_W'(g))) vld_q[g] <= 1'b0;
    end
  end

  ctx_ptr_pick #(.N(DEPTH)) u_hit_pick (
    .vec (hit_vec),
    .any (hit),
    .idx (hit_idx)
  );

  ctx_ptr_pick #(.N(DEPTH)) u_free_pick (
    .vec (free_vec),
    .any (free_any),
    .idx (free_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (wr_en) cnt_q <= cnt_q + CNT_W'(1);
    else if (clr_en) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign count = cnt_q;

endmodule

// File: rtl/ctx_ptr_cur.sv
module ctx_ptr_cur #(
  parameter int TAG_W = 52
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             drop_en,
  output logic             valid,
  output logic [TAG_W-1:0] tag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      tag   <= '0;
    end else if (set_en) begin
      valid <= 1'b1;
      tag   <= set_tag;
    end else if (drop_en) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ctx_ptr_tracker.sv
module ctx_ptr_tracker #(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12,
  parameter int DEPTH     = 8,
  localparam int TAG_W = ADDR_W - PAGE_BITS,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_ptr,
  output logic              op_grant,
  output logic              err_align,
  output logic              err_nocur,
  output logic              err_full,
  output logic              cur_valid,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic [CNT_W-1:0]  act_cnt
);
  import ctx_ptr_pkg::*;

  ctx_op_e          op;
  logic [TAG_W-1:0] cmd_tag;
  logic             misal;
  logic             is_load, is_clear, is_store, is_use;
  logic             hit, free_any;
  logic [IDX_W-1:0] hit_idx, free_idx;
  logic             tbl_wr, tbl_clr;
  logic             load_ok, load_full;
  logic             cur_drop;
  logic [TAG_W-1:0] cur_tag;

  assign op       = ctx_op_e'(cmd_op);
  assign cmd_tag  = cmd_addr[ADDR_W-1:PAGE_BITS];
  assign misal    = |cmd_addr[PAGE_BITS-1:0];
  assign is_load  = cmd_valid && (op == OP_LOAD);
  assign is_clear = cmd_valid && (op == OP_CLEAR);
  assign is_store = cmd_valid && (op == OP_STORE);
  assign is_use   = cmd_valid && op_uses_current(op);

  assign load_ok   = is_load && !misal && (hit || free_any);
  assign load_full = is_load && !misal && !hit && !free_any;
  assign tbl_wr    = is_load && !misal && !hit && free_any;
  assign tbl_clr   = is_clear && !misal && hit;
  assign cur_drop  = tbl_clr && cur_valid && (cur_tag == cmd_tag);

  ctx_ptr_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cam (
    .clk      (clk),
    .rst      (rst),
    .look_tag (cmd_tag),
    .wr_en    (tbl_wr),
    .wr_idx   (free_idx),
    .clr_en   (tbl_clr),
    .clr_idx  (hit_idx),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .free_any (free_any),
    .free_idx (free_idx),
    .count    (act_cnt)
  );

  ctx_ptr_cur #(.TAG_W(TAG_W)) u_cur (
    .clk     (clk),
    .rst     (rst),
    .set_en  (load_ok),
    .set_tag (cmd_tag),
    .drop_en (cur_drop),
    .valid   (cur_valid),
    .tag     (cur_tag)
  );

  assign cur_ptr = {cur_tag, {PAGE_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ptr   <= '0;
      op_grant  <= 1'b0;
      err_align <= 1'b0;
      err_nocur <= 1'b0;
      err_full  <= 1'b0;
    end else begin
      rsp_valid <= is_store;
      if (is_store) rsp_ptr <= cur_valid ? {cur_tag, {PAGE_BITS{1'b0}}} : '1;
      op_grant  <= is_use && cur_valid;
      err_nocur <= is_use && !cur_valid;
      err_align <= (is_load || is_clear) && misal;
      err_full  <= load_full;
    end
  end

endmodule

// File: rtl/ctx_ptr_tracker_chk.sv
module ctx_ptr_tracker_chk #(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12,
  parameter int DEPTH     = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_ptr,
  input logic              op_grant,
  input logic              err_align,
  input logic              err_nocur,
  input logic              err_full,
  input logic              cur_valid,
  input logic [ADDR_W-1:0] cur_ptr,
  input logic [CNT_W-1:0]  act_cnt
);

  logic c_misal, c_ldclr, c_use;
  assign c_misal = |cmd_addr[PAGE_BITS-1:0];
  assign c_ldclr = cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2);
  assign c_use   = cmd_valid && cmd_op[2];

  p_load_current_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd1 && !c_misal) |=>
      (err_full || (cur_valid && cur_ptr == $past(cmd_addr))));

  p_misaligned_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (c_ldclr && c_misal) |=>
      (err_align && $stable(cur_valid) && $stable(cur_ptr) && $stable(act_cnt)));

  p_clear_current_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd2 && !c_misal && cur_valid && cmd_addr == cur_ptr)
      |=> !cur_valid);

  p_current_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    cur_valid |-> (cur_ptr[PAGE_BITS-1:0] == '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    act_cnt <= CNT_W'(DEPTH));

  p_full_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    err_full |-> ($past(act_cnt) == CNT_W'(DEPTH) && $stable(act_cnt)));

  p_store_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd3 && !cur_valid) |=> (rsp_valid && rsp_ptr == '1));

  p_nocur_error_r9: assert property (@(posedge clk) disable iff (rst)
    (c_use && !cur_valid) |=> (err_nocur && !op_grant));

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    $countones({rsp_valid, op_grant, err_align, err_nocur, err_full}) <= 1);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !(rsp_valid || op_grant || err_align || err_nocur || err_full));

endmodule

bind ctx_ptr_tracker ctx_ptr_tracker_chk #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .rsp_valid(rsp_valid), .rsp_ptr(rsp_ptr),
  .op_grant(op_grant), .err_align(err_align), .err_nocur(err_nocur),
  .err_full(err_full), .cur_valid(cur_valid), .cur_ptr(cur_ptr),
  .act_cnt(act_cnt)
);

// File: tb/ctx_ptr_tracker_test.sv
`timescale 1ns/1ps
module ctx_ptr_tracker_test;

  localparam int POOL = 12;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [63:0] cmd_addr = '0;
  logic        rsp_valid, op_grant, err_align, err_nocur, err_full, cur_valid;
  logic [63:0] rsp_ptr, cur_ptr;
  logic [3:0]  act_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [POOL-1:0] m_act = '0;
  bit              m_cv = 0;
  int              m_ci = 0;

  always #2 clk = ~clk;

  ctx_ptr_tracker uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .rsp_valid(rsp_valid), .rsp_ptr(rsp_ptr),
    .op_grant(op_grant), .err_align(err_align), .err_nocur(err_nocur),
    .err_full(err_full), .cur_valid(cur_valid), .cur_ptr(cur_ptr),
    .act_cnt(act_cnt)
  );

  function automatic logic [63:0] addr_of(input int i);
    return 64'h8000_0000_0000_0000 + 64'(i) * 64'h0000_0100_0000_3000;
  endfunction

  task automatic run_cmd(input logic [2:0] op, input int idx, input logic [11:0] off);
    bit e_rsp = 0, e_gr = 0, e_al = 0, e_nc = 0, e_fu = 0;
    logic [63:0] e_ptr = '0;
    string tag = "R6";
    bit misal = (off != 0);
    bit ok;
    case (op)
      3'd1: begin
        if (misal) begin e_al = 1; tag = "R3"; end
        else if (m_act[idx]) begin m_cv = 1; m_ci = idx; tag = "R2"; end
        else if ($countones(m_act) < DEPTH) begin
          m_act[idx] = 1'b1; m_cv = 1; m_ci = idx; tag = "R2";
        end else begin e_fu = 1; tag = "R7"; end
      end
      3'd2: begin
        if (misal) begin e_al = 1; tag = "R3"; end
        else begin
          tag = (m_cv && m_ci == idx) ? "R5" : "R4";
          if (m_act[idx]) begin
            m_act[idx] = 1'b0;
            if (m_cv && m_ci == idx) m_cv = 0;
          end
        end
      end
      3'd3: begin e_rsp = 1; e_ptr = m_cv ? addr_of(m_ci) : '1; tag = "R8"; end
      3'd4, 3'd5, 3'd6, 3'd7: begin
        tag = "R9";
        if (m_cv) e_gr = 1; else e_nc = 1;
      end
      default: tag = "R6";
    endcase
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = addr_of(idx) | 64'(off);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    ok = (rsp_valid == e_rsp) && (op_grant == e_gr) && (err_align == e_al) &&
         (err_nocur == e_nc) && (err_full == e_fu) && (cur_valid == m_cv) &&
         (act_cnt == 4'($countones(m_act))) &&
         (!m_cv || cur_ptr == addr_of(m_ci)) && (!e_rsp || rsp_ptr == e_ptr);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s op=%0d: actual rsp=%0b ptr=%h gr=%0b al=%0b nc=%0b fu=%0b cv=%0b cp=%h cnt=%0d expected rsp=%0b ptr=%h gr=%0b al=%0b nc=%0b fu=%0b cv=%0b cp=%h cnt=%0d",
               tag, op, rsp_valid, rsp_ptr, op_grant, err_align, err_nocur, err_full,
               cur_valid, cur_ptr, act_cnt, e_rsp, e_ptr, e_gr, e_al, e_nc, e_fu,
               m_cv, m_cv ? addr_of(m_ci) : 64'h0, $countones(m_act));
    end
  endtask

  task automatic check_quiet(input string tag);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid || op_grant || err_align || err_nocur || err_full ||
        cur_valid != m_cv || act_cnt != 4'($countones(m_act))) begin
      errors++;
      $display("FAIL %s: actual pulses=%b cv=%0b cnt=%0d expected pulses=00000 cv=%0b cnt=%0d",
               tag, {rsp_valid, op_grant, err_align, err_nocur, err_full},
               cur_valid, act_cnt, m_cv, $countones(m_act));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (cur_valid || act_cnt != 0 || rsp_valid || op_grant || err_align || err_nocur || err_full) begin
      errors++;
      $display("FAIL R1: actual cv=%0b cnt=%0d pulses=%b expected cv=0 cnt=0 pulses=00000",
               cur_valid, act_cnt, {rsp_valid, op_grant, err_align, err_nocur, err_full});
    end
    run_cmd(3'd3, 0, 12'h0);    // R8 store with nothing current
    run_cmd(3'd4, 0, 12'h0);    // R9 read with nothing current
    run_cmd(3'd6, 0, 12'h0);    // R9 launch with nothing current
    run_cmd(3'd1, 0, 12'h800);  // R3 misaligned load
    run_cmd(3'd1, 0, 12'h0);    // R2
    check_quiet("R10");
    run_cmd(3'd1, 1, 12'h001);  // R3 misaligned load keeps current
    run_cmd(3'd2, 0, 12'h010);  // R3 misaligned clear of current
    run_cmd(3'd5, 0, 12'h0);    // R9 grant
    for (int i = 1; i < DEPTH; i++) run_cmd(3'd1, i, 12'h0);  // fill table
    run_cmd(3'd1, 9, 12'h0);    // R7 overflow
    run_cmd(3'd3, 0, 12'h0);    // R6/R8 current still the last load
    run_cmd(3'd1, 2, 12'h0);    // R7 reload existing while full
    run_cmd(3'd2, 5, 12'h0);    // R4/R5 clear non-current
    run_cmd(3'd2, 10, 12'h0);   // R4 clear of inactive address
    run_cmd(3'd1, 9, 12'h0);    // R2 slot reused
    run_cmd(3'd2, 9, 12'h0);    // R5 clear current
    run_cmd(3'd3, 0, 12'h0);    // R8 all ones
    run_cmd(3'd7, 0, 12'h0);    // R9 resume with nothing current
    check_quiet("R10");
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(0, 99));
      int idx = int'($urandom_range(0, POOL - 1));
      logic [11:0] off = ($urandom_range(0, 9) == 0) ? 12'($urandom_range(1, 4095)) : 12'h0;
      logic [2:0] op;
      if (r < 38) op = 3'd1;
      else if (r < 60) op = 3'd2;
      else if (r < 70) op = 3'd3;
      else if (r < 95) op = 3'(4 + (r % 4));
      else op = 3'd0;
      run_cmd(op, idx, off);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual run not finished expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule